// File: doc/BRIEF.md
# Ping-Pong Memory Read and Swap Controller

This block sits on the read side of a two-memory ping-pong frame store. One SDRAM takes camera lines from a separate writer while the other is drained into a downstream FIFO. The controller reads the read-side memory in short row bursts. Each burst is an activate, a run of consecutive reads and a precharge. It pushes the returned words into the FIFO whenever the FIFO reports room. A select output steers the external two-way switch, and a value of 0 puts memory A on the read side.

The controller holds two addresses. The resume address is the next word to read. The stop address is the last word the writer put into the memory now on the read side. When the stop word has reached the FIFO and the writer reports that it has finished its line gap and its own refresh, the controller flips the select. It then loads the writer's last-written address as the new stop address and restarts reading at address 0. A free-running timer asks for a refresh pass of the read-side memory. The pass starts only between bursts, and no FIFO data moves while it runs.

Back-pressure on the FIFO stream: `fifo_wvalid` has no ready. The FIFO raises `fifo_afull` early enough that a burst already started, up to `BURST_LEN` words plus the read latency, still fits. A new burst is started only in a cycle where `fifo_afull` is low.

Top module: `pingpong_rd_ctrl`

## Requirements
- R1: After reset `mem_sel` is 0, `sd_cmd` is idle (code 0) and `fifo_wvalid` is 0. No read is issued until the first swap has taken place.
- R2: Command codes are 0 idle, 1 activate, 2 read, 3 precharge and 4 refresh. A burst is an activate, then 1 to `BURST_LEN` reads at consecutive addresses, then a precharge. A burst starts only in the cycle after an idle cycle in which `fifo_afull` was low.
- R3: After a swap that captured last address L, exactly L+1 words, from addresses 0 through L, are read and pushed to the FIFO. No read goes past L.
- R4: `mem_sel` toggles only when the stop word has already been pushed to the FIFO and `wr_gap_done` was high in the cycle before the toggle.
- R5: At a swap, `wr_last_addr` becomes the new stop address and reading resumes at address 0 of the newly selected memory.
- R6: When `mem_sel` toggles, no row is open and no read data is still in flight.
- R7: The data word of each read command appears on `fifo_wdata`, with `fifo_wvalid` high, exactly `CAS_LAT` cycles after that read command.
- R8: A refresh pass is requested every `REF_INTERVAL` cycles. A pass is `REF_ROWS` refresh commands spaced exactly `REF_CYC` cycles apart.
- R9: A refresh command is never issued while a row is open, so a pass begins only at a burst boundary.
- R10: No FIFO write occurs during a refresh pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_afull | input | 1 | FIFO has no room for another burst |
| fifo_wvalid | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | Word written to the FIFO |
| sd_rdata | input | DATA_W | Read data returned by the read-side memory |
| sd_cmd | output | 3 | Memory command (R2 encoding) |
| sd_addr | output | ADDR_W | Word address for activate and read |
| wr_last_addr | input | ADDR_W | Last address written by the writer |
| wr_gap_done | input | 1 | Writer has finished its line gap and refresh |
| mem_sel | output | 1 | Switch select, 0 puts memory A on the read side |

## Verification
The assertions assume that `wr_last_addr` is stable while `wr_gap_done` is high. They also assume that read data returns exactly `CAS_LAT` cycles after each read command, and that the FIFO really accepts every word pushed after a burst began with `fifo_afull` low. The bench memory model returns data at that fixed latency. The data word encodes both the memory and the address. The bench changes `wr_last_addr` only while `wr_gap_done` is low, and it never drops a pushed word. This keeps the stimulus inside what the properties take for granted.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_REF = 3'd4
  } mem_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RD,
    ST_PRE,
    ST_WAIT,
    ST_REF
  } rd_state_e;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int INTERVAL = 6000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)     due <= 1'b1;
      else if (ack) due <= 1'b0;
    end
  end

  // R8
  ack_needs_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> due);
endmodule

// File: rtl/return_pipe.sv
module return_pipe #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic valid,
  output logic busy
);
  logic [LAT-1:0] sr;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= issue;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[LAT-2:0], issue};
      end
    end
  endgenerate

  assign valid = sr[LAT-1];
  assign busy  = |sr;
endmodule

// File: rtl/pingpong_rd_ctrl.sv
module pingpong_rd_ctrl
  import pingpong_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 10,
  parameter int BURST_LEN    = 8,
  parameter int CAS_LAT      = 2,
  parameter int REF_INTERVAL = 6000000,
  parameter int REF_ROWS     = 4096,
  parameter int REF_CYC      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_afull,
  output logic              fifo_wvalid,
  output logic [DATA_W-1:0] fifo_wdata,
  input  logic [DATA_W-1:0] sd_rdata,
  output logic [2:0]        sd_cmd,
  output logic [ADDR_W-1:0] sd_addr,
  input  logic [ADDR_W-1:0] wr_last_addr,
  input  logic              wr_gap_done,
  output logic              mem_sel
);
  localparam int BW  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int RCW = (REF_ROWS > 1) ? $clog2(REF_ROWS) : 1;
  localparam int WCW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;

  rd_state_e          st;
  logic [ADDR_W-1:0]  rd_ptr, stop_ptr;
  logic               reached, hit_pend, row_open;
  logic [BW-1:0]      beat;
  logic [RCW-1:0]     ref_n;
  logic [WCW-1:0]     ref_w;
  logic               ref_due, ref_ack, pipe_busy, at_stop, last_beat;
  mem_cmd_e           cmd;

  assign ref_ack   = (st == ST_IDLE) && ref_due;
  assign at_stop   = (rd_ptr == stop_ptr);
  assign last_beat = at_stop || (beat == BW'(BURST_LEN - 1));

  refresh_timer #(.INTERVAL(REF_INTERVAL)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
  );

  return_pipe #(.LAT(CAS_LAT)) u_ret (
    .clk(clk), .rst_n(rst_n), .issue(cmd == CMD_RD),
    .valid(fifo_wvalid), .busy(pipe_busy)
  );

  always_comb begin
    unique case (st)
      ST_ACT:  cmd = CMD_ACT;
      ST_RD:   cmd = CMD_RD;
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = (ref_w == '0) ? CMD_REF : CMD_NOP;
      default: cmd = CMD_NOP;
    endcase
  end

  assign sd_cmd     = cmd;
  assign sd_addr    = rd_ptr;
  assign fifo_wdata = sd_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rd_ptr   <= '0;
      stop_ptr <= '0;
      reached  <= 1'b1;
      hit_pend <= 1'b0;
      beat     <= '0;
      ref_n    <= '0;
      ref_w    <= '0;
      mem_sel  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (ref_due) begin
            st    <= ST_REF;
            ref_n <= '0;
            ref_w <= '0;
          end else if (reached && wr_gap_done) begin
            mem_sel  <= ~mem_sel;
            stop_ptr <= wr_last_addr;
            rd_ptr   <= '0;
            reached  <= 1'b0;
          end else if (!reached && !fifo_afull) begin
            st   <= ST_ACT;
            beat <= '0;
          end
        end
        ST_ACT: st <= ST_RD;
        ST_RD: begin
          rd_ptr <= rd_ptr + 1'b1;
          beat   <= beat + 1'b1;
          if (last_beat) begin
            hit_pend <= at_stop;
            st       <= ST_PRE;
          end
        end
        ST_PRE: st <= ST_WAIT;
        ST_WAIT: begin
          if (!pipe_busy) begin
            st <= ST_IDLE;
            if (hit_pend) begin
              reached  <= 1'b1;
              hit_pend <= 1'b0;
            end
          end
        end
        ST_REF: begin
          if (ref_w == WCW'(REF_CYC - 1)) begin
            ref_w <= '0;
            if (ref_n == RCW'(REF_ROWS - 1)) st <= ST_IDLE;
            else                             ref_n <= ref_n + 1'b1;
          end else begin
            ref_w <= ref_w + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Row tracking from the command stream, used only by the checks below
  always_ff @(posedge clk) begin
    if (!rst_n)                row_open <= 1'b0;
    else if (cmd == CMD_ACT)   row_open <= 1'b1;
    else if (cmd == CMD_PRE)   row_open <= 1'b0;
  end

  // R2
  act_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_ACT) |-> !$past(fifo_afull));
  // R3
  rd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_RD) |-> (sd_addr <= stop_ptr));
  // R4
  sel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel != $past(mem_sel)) |-> $past(wr_gap_done));
  // R6
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel != $past(mem_sel)) |-> (!row_open && !pipe_busy));
  // R9
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_REF) |-> !row_open);
  // R10
  ref_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_REF) |-> !fifo_wvalid);
endmodule

// File: tb/pingpong_rd_ctrl_tb.sv
module pingpong_rd_ctrl_tb;
  localparam int DW = 16, AW = 8, BL = 4, CL = 2;
  localparam int RI = 400, RR = 4, RC = 3;
  localparam logic [15:0] VEC [5] = '{16'h0500, 16'h0000, 16'h0B14, 16'h0300, 16'h0828};

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_afull = 1'b0, wr_gap_done = 1'b0;
  logic [AW-1:0] wr_last_addr = '0;
  logic fifo_wvalid, mem_sel;
  logic [DW-1:0] fifo_wdata, sd_rdata;
  logic [2:0] sd_cmd;
  logic [AW-1:0] sd_addr;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] got [512];
  int got_n = 0, n_ref = 0;
  int e_r2 = 0, e_r6 = 0, e_r7 = 0, e_r8 = 0, e_r9 = 0, e_r10 = 0;

  always #2 clk = ~clk;

  pingpong_rd_ctrl #(.DATA_W(DW), .ADDR_W(AW), .BURST_LEN(BL), .CAS_LAT(CL),
    .REF_INTERVAL(RI), .REF_ROWS(RR), .REF_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_afull(fifo_afull), .fifo_wvalid(fifo_wvalid),
    .fifo_wdata(fifo_wdata), .sd_rdata(sd_rdata), .sd_cmd(sd_cmd), .sd_addr(sd_addr),
    .wr_last_addr(wr_last_addr), .wr_gap_done(wr_gap_done), .mem_sel(mem_sel));

  // Memory model: word = memory tag | address, returned CL cycles after a read
  logic [CL-1:0] mdl_v = '0;
  logic [DW-1:0] mdl_d [CL];
  always @(posedge clk) begin
    mdl_v <= {mdl_v[CL-2:0], (sd_cmd == 3'd2)};
    mdl_d[0] <= (mem_sel ? 16'hB000 : 16'hA000) | DW'(sd_addr);
    for (int k = 1; k < CL; k++) mdl_d[k] <= mdl_d[k-1];
  end
  assign sd_rdata = mdl_d[CL-1];

  function automatic logic [DW-1:0] exp_word(input logic s, input int a);
    return (s ? 16'hB000 : 16'hA000) | DW'(a);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor, sampled mid-cycle
  logic prev_afull = 1'b0, prev_sel = 1'b0, row_open = 1'b0;
  int cyc = 0, last_ref = -1000, run = 0, win = 0;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (fifo_wvalid) begin got[got_n % 512] = fifo_wdata; got_n++; end
    if (fifo_wvalid != mdl_v[CL-1]) e_r7++;                        // R7
    if (sd_cmd == 3'd1 && prev_afull) e_r2++;                      // R2
    if (mem_sel != prev_sel && (row_open || mdl_v != '0)) e_r6++;  // R6
    if (fifo_wvalid && win > 0) e_r10++;                           // R10
    if (win > 0) win--;
    if (sd_cmd == 3'd4) begin
      if (row_open) e_r9++;                                        // R9
      n_ref++;
      win = RC;
      if (cyc - last_ref == RC) run++;
      else if (cyc - last_ref < RC) e_r8++;                        // R8
      else begin
        if (run != 0 && run != RR) e_r8++;
        run = 1;
      end
      last_ref = cyc;
    end
    if (sd_cmd == 3'd1) row_open = 1'b1;
    if (sd_cmd == 3'd3) row_open = 1'b0;
    prev_afull = fifo_afull;
    prev_sel = mem_sel;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic swap_to(input int last, output logic ok);
    logic s0;
    s0 = mem_sel;
    wr_last_addr = AW'(last);
    wr_gap_done = 1'b1;
    ok = 1'b0;
    for (int t = 0; t < 100 && !ok; t++) begin
      tick(1);
      if (mem_sel != s0) ok = 1'b1;
    end
    wr_gap_done = 1'b0;
  endtask

  task automatic finish_run();
    chk("R2 act while full", e_r2, 0);
    chk("R6 swap with open row", e_r6, 0);
    chk("R7 data timing", e_r7, 0);
    chk("R8 refresh spacing", e_r8, 0);
    chk("R9 refresh in burst", e_r9, 0);
    chk("R10 push in refresh", e_r10, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok;
    int base, bad, nref0;
    tick(4);
    // R1 reset state
    chk("R1 sel", mem_sel, 0);
    chk("R1 cmd", sd_cmd, 0);
    chk("R1 wvalid", fifo_wvalid, 0);
    rst_n = 1'b1;
    tick(40);
    chk("R1 no read before swap", got_n, 0);

    // R4: data pending, writer ready -> no swap until stop word is pushed
    fifo_afull = 1'b1;
    swap_to(20, ok);
    chk("R4 first swap", ok, 1);
    wr_gap_done = 1'b1;
    tick(60);
    chk("R4 held while unread", mem_sel, 1);
    chk("R2 nothing while full", got_n, 0);
    fifo_afull = 1'b0;
    tick(200);
    chk("R4 swap after drain", mem_sel, 0);
    wr_gap_done = 1'b0;
    tick(200);

    foreach (VEC[i]) begin
      int last, hold;
      last = int'(VEC[i][15:8]);
      hold = int'(VEC[i][7:0]);
      base = got_n;
      fifo_afull = (hold != 0);
      swap_to(last, ok);
      chk("R4 swap taken", ok, 1);
      if (hold != 0) begin
        tick(hold);
        chk("R2 held off by afull", got_n - base, 0);
        fifo_afull = 1'b0;
      end
      tick(150);
      chk("R3 word count", got_n - base, last + 1);
      chk("R5 restart at 0", int'(got[base % 512]), int'(exp_word(mem_sel, 0)));
      bad = 0;
      for (int j = 0; j <= last; j++)
        if (got[(base + j) % 512] != exp_word(mem_sel, j)) bad++;
      chk("R7 data order", bad, 0);
    end

    // R8: idle window, passes keep coming
    nref0 = n_ref;
    tick(4 * RI);
    chk("R8 passes in window", int'((n_ref - nref0) >= 3 * RR && (n_ref - nref0) <= 5 * RR), 1);
    base = got_n;
    tick(50);
    chk("R3 no read past stop", got_n - base, 0);
    finish_run();
  end
endmodule